// File: doc/BRIEF.md
# Serial 1011 Sequence Detector

This block consumes a one-bit serial stream, one bit on every rising clock edge, and flags each time the four most recently received bits, oldest first, form the pattern 1, 0, 1, 1. It is a five-state Moore machine. Its output is a function of the state register only, so the flag rises in the cycle after the fourth pattern bit has been clocked in.

Matches may overlap. The trailing "1" of one match can begin the next match, and so can a following "10". The state register is driven out on a 3-bit port with a fixed encoding. An external checker can therefore drive single bits and read back every transition of the machine directly.

A synchronous, active-high reset returns the machine to its idle state.

Top module: `seq1011_detect`

## Requirements
- R1: A rising clock edge with `rst_i` high sets `state_o` to 3'b000 and `hit_o` to 0, whatever the value of `bit_i`.
- R2: `state_o` reports the match progress with this encoding: 3'b000 means no progress, 3'b001 means "1" seen, 3'b010 means "10", 3'b011 means "101", and 3'b100 means "1011".
- R3: `hit_o` is 1 exactly when the last four bits taken since reset, oldest first, were 1,0,1,1. Fewer than four bits since reset never give a hit.
- R4: Detection overlaps. From the match state, a 1 moves to 3'b001 and a 0 moves to 3'b010. For example, the stream 1011011 gives two hits, three cycles apart.
- R5: Exactly one bit of `bit_i` is taken on each rising edge. A 0 in the idle state or in the "10" state returns to idle. A 1 in the "1" state stays there. A 0 in the "101" state moves to "10".
- R6: `state_o` never shows a value above 3'b100 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data bit taken each cycle |
| hit_o | output | 1 | High while the machine is in the match state |
| state_o | output | 3 | Current state code |

## Verification
Because the state register is driven straight to `state_o`, a wrong transition arc shows up at the ports on the very next edge as a mismatched state code. The bench compares that code every cycle against a table model. A fault that affects only the flag logic would leave `state_o` correct. The bench catches it through a separate check: it keeps a four-bit shift history of the stream and counts bits since reset, then compares `hit_o` against that, so a missed or spurious hit is reported in the cycle it occurs.

// File: rtl/seq1011_detect.sv
module seq1011_detect (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       bit_i,
  output logic       hit_o,
  output logic [2:0] state_o
);

  localparam logic [2:0] ST_IDLE = 3'b000;
  localparam logic [2:0] ST_ONE  = 3'b001;
  localparam logic [2:0] ST_OZ   = 3'b010;
  localparam logic [2:0] ST_OZO  = 3'b011;
  localparam logic [2:0] ST_HIT  = 3'b100;

  logic [2:0] cur_q, nxt;

  always_comb begin
    case (cur_q)
      ST_IDLE: nxt = bit_i ? ST_ONE : ST_IDLE;
      ST_ONE:  nxt = bit_i ? ST_ONE : ST_OZ;
      ST_OZ:   nxt = bit_i ? ST_OZO : ST_IDLE;
      ST_OZO:  nxt = bit_i ? ST_HIT : ST_OZ;
      ST_HIT:  nxt = bit_i ? ST_ONE : ST_OZ;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) cur_q <= ST_IDLE;
    else       cur_q <= nxt;
  end

  assign state_o = cur_q;
  assign hit_o   = (cur_q == ST_HIT);

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    rst_i |=> (state_o == ST_IDLE && !hit_o)); // R1
  AST_HIT_ON_PATTERN: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == ST_OZO && bit_i) |=> hit_o); // R3
  AST_NO_HIT_AFTER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !bit_i |=> !hit_o); // R3
  AST_OVERLAP_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_o && bit_i) |=> (state_o == ST_ONE)); // R4
  AST_OVERLAP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_o && !bit_i) |=> (state_o == ST_OZ)); // R4
  AST_ONE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == ST_ONE && bit_i) |=> $stable(state_o)); // R5
  AST_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
    state_o <= ST_HIT); // R6

endmodule

// File: tb/seq1011_detect_tb_top.sv
`timescale 1ns/1ps
module seq1011_detect_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic       bit_i = 1'b0;
  logic       hit_o;
  logic [2:0] state_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [2:0]  m_state = 3'b000;
  logic [3:0]  m_hist = 4'b0000;
  int unsigned m_cnt = 0;
  int unsigned hits_seen = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  seq1011_detect dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .bit_i(bit_i),
    .hit_o(hit_o), .state_o(state_o)
  );

  function automatic logic [2:0] ref_next(input logic [2:0] s, input logic b);
    case (s)
      3'b000: return b ? 3'b001 : 3'b000;
      3'b001: return b ? 3'b001 : 3'b010;
      3'b010: return b ? 3'b011 : 3'b000;
      3'b011: return b ? 3'b100 : 3'b010;
      3'b100: return b ? 3'b001 : 3'b010;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic ref_hit(input logic [3:0] h, input int unsigned c);
    return (c >= 4) && (h == 4'b1011);
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic b, input logic r, input string req);
    bit_i = b;
    rst_i = r;
    if (r) begin
      m_state = 3'b000; m_hist = 4'b0000; m_cnt = 0;
    end else begin
      m_state = ref_next(m_state, b);
      m_hist  = {m_hist[2:0], b};
      m_cnt++;
    end
    @(negedge clk_i);
    check({req, " state"}, {1'b0, state_o}, {1'b0, m_state});
    check({req, " hit"}, {3'b000, hit_o}, {3'b000, ref_hit(m_hist, m_cnt)});
    if (hit_o === 1'b1) hits_seen++;
  endtask

  task automatic feed(input logic [15:0] pat, input int len, input string req);
    for (int i = len - 1; i >= 0; i--) step(pat[i], 1'b0, req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk_i);
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, "R1");
    // R2 walk through every code
    feed(16'b1011, 4, "R2");
    // R4 overlap: 1011011 -> two hits
    step(1'b0, 1'b1, "R1");
    hits_seen = 0;
    feed(16'b1011011, 7, "R4");
    check("R4 hit count", 4'(hits_seen), 4'd2);
    // R4 zero after match
    feed(16'b1011, 4, "R4");
    feed(16'b011, 3, "R4");
    // R5 arcs: 0 in idle, 11 hold, 100, 1010
    step(1'b0, 1'b1, "R1");
    feed(16'b0011100, 7, "R5");
    feed(16'b1010, 4, "R5");
    // R1 reset mid-pattern, then short stream gives no hit
    feed(16'b101, 3, "R1");
    step(1'b1, 1'b1, "R1");
    feed(16'b011, 3, "R3");
    // R3 random stream with occasional reset
    for (int k = 0; k < 3000; k++) begin
      logic b;
      b = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) == 0) step(b, 1'b1, "R1");
      else step(b, 1'b0, "R3");
      check("R6 legal", {1'b0, state_o} <= 4'd4 ? 4'd1 : 4'd0, 4'd1);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule